// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of an 8-bit successive-approximation converter. It drives a trial code to an external DAC and takes back one comparator bit per trial. The trials run at one eighth of the external clock. A single marker bit moves down an 8-stage shift register, and its position selects the bit under trial. The MSB is tried first. When the marker leaves the last stage, the finished word is copied into an output latch and the active-low interrupt is asserted.

A microprocessor drives the block through an active-low select, an active-low write that starts a conversion, and an active-low read that enables the result and clears the interrupt. When the interrupt fires, a set pulse of eight external clocks holds it asserted. This set pulse wins over a read, so a bus that keeps select and read low all the time still sees the end-of-conversion pulse. If the interrupt is wired back to write and select is tied low, the block converts continuously and emits a one-clock interrupt pulse per result. True tri-state pads are not modelled: the output-enable condition appears as `dataValid`, and `dataOut` reads zero while it is low.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `intrN` is 1, `dacCode` is 0 and `dataValid` is 0.
- R2: The comparator input is sampled at the end of each trial. A 1 keeps the trial bit and a 0 clears it. With a comparator that reports `dacCode <= vin`, the converted result equals `vin`.
- R3: Successive trials are exactly 8 external clocks apart. The interrupt falls between 65 and 72 clocks, inclusive, after write is released.
- R4: The first nonzero trial code after a start is 0x80 (MSB trial), and each later trial sets the next lower bit.
- R5: While `csN` and `wrN` are both low, `dacCode` is held at 0 and `intrN` is held at 1. No conversion advances.
- R6: The interrupt only falls at the clock edge where the last trial completes, and the output latch already holds the new result in the first cycle that `intrN` is low.
- R7: `dataValid` is 1 exactly when `csN` and `rdN` are both low. `dataOut` shows the latched result then and 0 otherwise.
- R8: A read (`csN` and `rdN` low) given after the set pulse has ended returns `intrN` to 1 at the next clock edge.
- R9: When read is held low throughout a conversion, `intrN` is still low for exactly 8 clocks at completion, because the set pulse takes priority over the read clear.
- R10: Without a read or a start, `intrN` stays low indefinitely after completion.
- R11: A start during a conversion aborts it, and the next result is that of the new conversion.
- R12: With `wrN` fed back from `intrN` and `csN` low, conversions repeat every 72 clocks. Each `intrN` pulse is exactly 1 clock wide.
- R13: With `csN` high, `wrN` and `rdN` have no effect: no start, no interrupt clear, `dataValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Start request, active low |
| rdN | input | 1 | Read enable, active low |
| cmpIn | input | 1 | Comparator result for the current trial code |
| dacCode | output | 8 | Trial code to the DAC |
| dataOut | output | 8 | Latched result, zero when not enabled |
| dataValid | output | 1 | Output enable (stands in for tri-state drive) |
| intrN | output | 1 | End-of-conversion interrupt, active low |

## Verification
The bench models the comparator against a chosen input level and covers the extreme codes 0x00 and 0xFF as well as mixed patterns. It includes the case where read is held low through a whole conversion. If the design let the read clear win over the set pulse, the interrupt would never be seen there, or it would be shorter than 8 clocks. An abort partway through a conversion is checked: a design that failed to clear the marker would finish early with a mix of the two inputs. In the free-running loop, the interrupt width and the 72-clock period are measured. A design that cleared the interrupt too slowly would stretch the period, and one that cleared it combinationally would give a pulse the loop never sees. Select-high cases confirm that write and read are ignored.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic clear;  // start request: empty the trial register
    logic load;   // first internal tick after start: try the MSB
    logic trial;  // internal tick: resolve the bit under the marker
    logic done;   // trial on the last marker stage
  } sarStrobe_t;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int DIV     = 8,
  parameter int SET_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             readReq,
  output sarStrobe_t       strobe,
  output logic [WIDTH-1:0] trialMask,
  output logic             intrN
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SET_W = (SET_LEN > 1) ? $clog2(SET_LEN) : 1;
  localparam logic [WIDTH-1:0] MSB_MARK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             armed;
  logic [WIDTH-1:0] marker;
  logic [SET_W-1:0] setCnt;
  logic             intrFlag;

  assign tick = (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  // marker shift register; armed waits for the first tick after start
  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      marker <= '0;
    end else if (startReq) begin
      armed  <= 1'b1;
      marker <= '0;
    end else if (tick && armed) begin
      armed  <= 1'b0;
      marker <= MSB_MARK;
    end else if (tick && (|marker)) begin
      marker <= marker >> 1;
    end
  end

  always_comb begin
    strobe.clear = startReq;
    strobe.load  = !startReq && tick && armed;
    strobe.trial = !startReq && tick && !armed && (|marker);
    strobe.done  = strobe.trial && marker[0];
  end
  assign trialMask = marker;

  // interrupt flip-flop: start clears, set pulse dominates read clear
  always_ff @(posedge clk) begin
    if (rst || startReq) begin
      setCnt   <= '0;
      intrFlag <= 1'b0;
    end else if (strobe.done) begin
      setCnt   <= SET_W'(SET_LEN - 1);
      intrFlag <= 1'b1;
    end else if (setCnt != '0) begin
      setCnt   <= setCnt - 1'b1;
      intrFlag <= 1'b1;
    end else if (readReq) begin
      intrFlag <= 1'b0;
    end
  end
  assign intrN = !intrFlag;
endmodule

// File: rtl/sar_adc_path.sv
module sar_adc_path
  import sar_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sarStrobe_t       strobe,
  input  logic [WIDTH-1:0] trialMask,
  input  logic             cmpIn,
  input  logic             readReq,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut
);
  localparam logic [WIDTH-1:0] MSB_MARK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sarQ;
  logic [WIDTH-1:0] resultQ;
  logic [WIDTH-1:0] keepCode;

  assign keepCode = cmpIn ? sarQ : (sarQ & ~trialMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.clear)      sarQ <= '0;
      else if (strobe.load)  sarQ <= MSB_MARK;
      else if (strobe.trial) sarQ <= keepCode | (trialMask >> 1);
      if (strobe.done) resultQ <= keepCode;
    end
  end

  assign dacCode = sarQ;
  assign dataOut = readReq ? resultQ : '0;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int DIV     = 8,
  parameter int SET_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid,
  output logic             intrN
);
  logic             startReq;
  logic             readReq;
  sarStrobe_t       strobe;
  logic [WIDTH-1:0] trialMask;

  assign startReq  = !csN && !wrN;
  assign readReq   = !csN && !rdN;
  assign dataValid = readReq;

  sar_adc_seq #(.WIDTH(WIDTH), .DIV(DIV), .SET_LEN(SET_LEN)) seq_i (
    .clk(clk), .rst(rst), .startReq(startReq), .readReq(readReq),
    .strobe(strobe), .trialMask(trialMask), .intrN(intrN)
  );

  sar_adc_path #(.WIDTH(WIDTH)) path_i (
    .clk(clk), .rst(rst), .strobe(strobe), .trialMask(trialMask),
    .cmpIn(cmpIn), .readReq(readReq), .dacCode(dacCode), .dataOut(dataOut)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_adc_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DIV   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             csN,
  input logic             wrN,
  input logic             intrN,
  input logic [WIDTH-1:0] dacCode,
  input sarStrobe_t       strobe
);
  localparam int GAP_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [WIDTH-1:0] MSB_MARK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [GAP_W-1:0] gapCnt;
  logic             seenTrial;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '0;
      seenTrial <= 1'b0;
    end else if (strobe.trial || strobe.load) begin
      gapCnt    <= '0;
      seenTrial <= 1'b1;
    end else if (gapCnt == GAP_W'(DIV - 1)) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (intrN && dacCode == '0)); // R1

  AST_TRIAL_SPACING: assert property (@(posedge clk) disable iff (rst)
    ((strobe.trial || strobe.load) && seenTrial) |-> gapCnt == GAP_W'(DIV - 1)); // R3

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($past(dacCode) == '0 && dacCode != '0) |-> dacCode == MSB_MARK); // R4

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!csN && !wrN) |=> (intrN && dacCode == '0)); // R5

  AST_INTR_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(intrN) |-> $past(strobe.done)); // R6

  AST_DONE_FIRES: assert property (@(posedge clk) disable iff (rst)
    strobe.done |=> !intrN); // R9
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH), .DIV(DIV)) chk_i (
  .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .intrN(intrN),
  .dacCode(dacCode), .strobe(strobe)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1;
  logic       wrDrv = 1'b1;
  logic       rdN = 1'b1;
  logic       freeRun = 1'b0;
  logic [7:0] vin = 8'h00;
  logic       wrN;
  logic       cmpIn;
  logic [7:0] dacCode;
  logic [7:0] dataOut;
  logic       dataValid;
  logic       intrN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign wrN   = freeRun ? (intrN & wrDrv) : wrDrv;
  assign cmpIn = (dacCode <= vin);

  sar_adc_ctrl dut_i (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .rdN(rdN), .cmpIn(cmpIn),
    .dacCode(dacCode), .dataOut(dataOut), .dataValid(dataValid), .intrN(intrN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // start pulse; returns clocks from write release to interrupt fall, and first nonzero code
  task automatic start_and_wait(output int lat, output logic [7:0] firstCode);
    lat = 0;
    firstCode = 8'h00;
    @(negedge clk);
    csN = 1'b0; wrDrv = 1'b0;
    repeat (3) @(negedge clk);
    chk(dacCode == 8'h00 && intrN == 1'b1, "R5", {dacCode, 7'b0, intrN}, 16'h0001);
    wrDrv = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      lat++;
      if (firstCode == 8'h00 && dacCode != 8'h00) firstCode = dacCode;
      if (!intrN) break;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(intrN == 1'b1 && dacCode == 8'h00 && dataValid == 1'b0, "R1",
        {intrN, dacCode, dataValid}, 10'h200);
    rst = 1'b0;
  endtask

  task automatic t_convert(input logic [7:0] v);
    int lat;
    logic [7:0] fc;
    vin = v;
    start_and_wait(lat, fc);
    chk(lat >= 65 && lat <= 72, "R3", lat, 72);
    chk(fc == 8'h80, "R4", fc, 8'h80);
    chk(dataValid == 1'b0 && dataOut == 8'h00, "R7", {dataValid, dataOut}, 0);
    repeat (20) @(negedge clk);
    chk(intrN == 1'b0, "R10", intrN, 0);
    rdN = 1'b0;
    #1;
    chk(dataValid == 1'b1 && dataOut == v, "R2", dataOut, v);
    @(negedge clk);
    chk(intrN == 1'b1, "R8", intrN, 1);
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic t_read_held(input logic [7:0] v);
    int lat;
    int lowCnt;
    logic [7:0] fc;
    vin = v;
    rdN = 1'b0;
    start_and_wait(lat, fc);
    chk(dataOut == v, "R6", dataOut, v);
    lowCnt = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (intrN) break;
      lowCnt++;
    end
    chk(lowCnt == 8, "R9", lowCnt, 8);
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic t_abort(input logic [7:0] a, input logic [7:0] b);
    int lat;
    logic [7:0] fc;
    vin = a;
    @(negedge clk);
    csN = 1'b0; wrDrv = 1'b0;
    @(negedge clk);
    wrDrv = 1'b1;
    repeat (35) @(negedge clk);
    vin = b;
    start_and_wait(lat, fc);
    chk(lat >= 65 && lat <= 72, "R11", lat, 72);
    rdN = 1'b0;
    #1;
    chk(dataOut == b, "R11", dataOut, b);
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic t_cs_ignore();
    logic [7:0] held;
    int lat;
    logic [7:0] fc;
    vin = 8'h5A;
    start_and_wait(lat, fc);
    csN = 1'b1;
    held = dacCode;
    wrDrv = 1'b0; rdN = 1'b0;
    repeat (20) @(negedge clk);
    chk(dacCode == held && intrN == 1'b0, "R13", {dacCode, intrN}, {held, 1'b0});
    chk(dataValid == 1'b0 && dataOut == 8'h00, "R13", {dataValid, dataOut}, 0);
    wrDrv = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_free_run(input logic [7:0] v);
    int lat;
    int width;
    int period;
    logic [7:0] fc;
    vin = v;
    freeRun = 1'b1;
    start_and_wait(lat, fc);
    width = 0;
    for (int i = 0; i < 10; i++) begin
      if (intrN) break;
      width++;
      @(negedge clk);
    end
    chk(width == 1, "R12", width, 1);
    period = width;
    for (int i = 0; i < 200; i++) begin
      if (!intrN) break;
      period++;
      @(negedge clk);
    end
    chk(period == 72, "R12", period, 72);
    rdN = 1'b0;
    #1;
    chk(dataOut == v, "R12", dataOut, v);
    rdN = 1'b1;
    @(negedge clk);
    freeRun = 1'b0; csN = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_convert(8'hA5);
    t_convert(8'h00);
    t_convert(8'hFF);
    t_convert(8'h3C);
    t_read_held(8'h81);
    t_abort(8'h11, 8'hE7);
    t_cs_ignore();
    t_free_run(8'h69);
    finish_run();
  end
endmodule